// File: doc/BRIEF.md
# Dual-Clock Shift-and-Hold Register

This block collects serial data into a chain of flip-flops on one clock and copies the whole chain into a parallel holding register on a second, independent clock. The holding register drives a parallel output bus that can be switched to high impedance by an active-low enable. The same value is also available as a plain data vector with a separate drive flag for on-chip use. The last stage of the chain is brought out as a serial output, so several blocks can be chained into a longer register.

An active-low asynchronous clear empties the chain at once and leaves the holding register alone. A controller can therefore shift in a new word and reset the chain while the outputs keep showing the last stored word. When both clocks are driven from one source, the holding register takes the chain's value from before that edge's shift. The parallel outputs then trail the chain by one pulse.

Top module: `serial_hold_reg`

## Requirements
- R1: While `clr_n` is low, every chain stage is 0 and `ser_out` reads 0, with no clock edge needed. A shift edge after release starts from an empty chain.
- R2: On each rising edge of `shift_clk` (with `clr_n` high), stage 0 takes `ser_in` and every stage k+1 takes the old value of stage k.
- R3: On each rising edge of `hold_clk`, `par_data` takes all chain stages in parallel, with bit k equal to stage k. It changes on no other event.
- R4: Asserting `clr_n` leaves `par_data` and the enabled `par_bus` unchanged.
- R5: With `out_en_n` high, `par_drive` is 0 and `par_bus` is high impedance. With `out_en_n` low, `par_drive` is 1 and `par_bus` equals `par_data`.
- R6: `ser_out` always equals the last chain stage, whatever the state of `out_en_n`.
- R7: When `shift_clk` and `hold_clk` rise together, `par_data` takes the chain value from before that shift, so the outputs lag the chain by one pulse.
- R8: Two instances, with the serial output of the first feeding the serial input of the second, form a 2×STAGES chain. After 16 bits are shifted in MSB first, `{upper.par_data, lower.par_data}` equals the 16-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Chain clock, rising edge |
| hold_clk | input | 1 | Holding-register clock, rising edge |
| clr_n | input | 1 | Asynchronous chain clear, active low |
| ser_in | input | 1 | Serial data into stage 0 |
| out_en_n | input | 1 | Parallel output enable, active low |
| par_bus | output | STAGES | Tri-state parallel output |
| par_data | output | STAGES | Holding register contents, always driven |
| par_drive | output | 1 | High when `par_bus` is driven |
| ser_out | output | 1 | Last chain stage, used for cascading |

## Verification
The chain and `ser_out` settle on the same `shift_clk` rising edge that shifts them. `par_data` settles on the `hold_clk` rising edge. The clear and the enable take effect without any edge. The bench drives each clock as a single pulse from a task and samples results 5 ns after the falling half of that pulse, well clear of any edge. Clear and enable effects are sampled a few nanoseconds after the input changes. In the tied-clock cases both edges share one pulse, and the expected held value is the chain word tracked before that pulse.

// File: rtl/serial_hold_reg.sv
module serial_hold_reg #(
  parameter int STAGES = 8
) (
  input  logic              shift_clk,
  input  logic              hold_clk,
  input  logic              clr_n,
  input  logic              ser_in,
  input  logic              out_en_n,
  output wire [STAGES-1:0]  par_bus,
  output logic [STAGES-1:0] par_data,
  output logic              par_drive,
  output logic              ser_out
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic [STAGES-1:0] held;

  always_ff @(posedge shift_clk or negedge clr_n)
    if (!clr_n) chain <= '0;
    else        chain <= {chain[LAST-1:0], ser_in};

  always_ff @(posedge hold_clk)
    held <= chain;

  assign ser_out   = chain[LAST];
  assign par_data  = held;
  assign par_drive = ~out_en_n;
  assign par_bus   = out_en_n ? {STAGES{1'bz}} : held;

  // R2
  entry_shift_chk: assert property (@(posedge shift_clk) disable iff (!clr_n)
    1'b1 |=> chain[0] == $past(ser_in));

  // R2
  stage_move_chk: assert property (@(posedge shift_clk) disable iff (!clr_n)
    1'b1 |=> chain[LAST:1] == $past(chain[LAST-1:0]));

  // R6
  cascade_out_chk: assert property (@(posedge shift_clk) disable iff (!clr_n)
    1'b1 |=> ser_out == $past(chain[LAST-1]));

  // R3
  hold_capture_chk: assert property (@(posedge hold_clk) disable iff (!clr_n)
    1'b1 |=> par_data == $past(chain));
endmodule

// File: tb/tb_serial_hold_reg.sv
module tb_serial_hold_reg;
  localparam int  W    = 8;
  localparam time HALF = 10;
  localparam logic [15:0] VEC [4] = '{16'hA5C3, 16'h0001, 16'h8000, 16'hFFFF};

  logic shift_clk = 0, hold_clk = 0, clr_n = 0, out_en_n = 0, ser_in = 0;
  wire [W-1:0] lo_bus, hi_bus;
  wire [W-1:0] lo_data, hi_data;
  wire lo_drv, hi_drv, lo_so, hi_so;
  int checks = 0, fails = 0;
  logic [15:0] track;

  serial_hold_reg #(.STAGES(W)) dut (
    .shift_clk(shift_clk), .hold_clk(hold_clk), .clr_n(clr_n), .ser_in(ser_in),
    .out_en_n(out_en_n), .par_bus(lo_bus), .par_data(lo_data),
    .par_drive(lo_drv), .ser_out(lo_so));

  serial_hold_reg #(.STAGES(W)) dut_hi (
    .shift_clk(shift_clk), .hold_clk(hold_clk), .clr_n(clr_n), .ser_in(lo_so),
    .out_en_n(out_en_n), .par_bus(hi_bus), .par_data(hi_data),
    .par_drive(hi_drv), .ser_out(hi_so));

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b; #5; shift_clk = 1; #HALF; shift_clk = 0; #5;
  endtask

  task automatic store();
    #5; hold_clk = 1; #HALF; hold_clk = 0; #5;
  endtask

  task automatic both(input logic b);
    ser_in = b; #5; shift_clk = 1; hold_clk = 1; #HALF; shift_clk = 0; hold_clk = 0; #5;
  endtask

  task automatic shift_word(input logic [15:0] p);
    for (int i = 15; i >= 0; i--) shift_bit(p[i]);
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state, no clock yet
    #12;
    check(lo_so == 0 && hi_so == 0, "R1 ser_out in clear", {14'h0, hi_so, lo_so}, 16'h0);
    clr_n = 1; #10;
    store();
    check({hi_data, lo_data} == 16'h0, "R3 first capture of empty chain", {hi_data, lo_data}, 16'h0);

    // R8 / R2: vector table walk through the cascade
    for (int v = 0; v < 4; v++) begin
      shift_word(VEC[v]);
      check(hi_so == VEC[v][15], "R6 upper ser_out is last stage", {15'h0, hi_so}, {15'h0, VEC[v][15]});
      store();
      check({hi_data, lo_data} == VEC[v], "R8 cascaded word", {hi_data, lo_data}, VEC[v]);
      check({hi_bus, lo_bus} == VEC[v], "R5 enabled bus follows data", {hi_bus, lo_bus}, VEC[v]);
    end

    // R3: shifting alone does not move the held word
    shift_word(16'h5A0F);
    check({hi_data, lo_data} == 16'hFFFF, "R3 no capture without hold edge", {hi_data, lo_data}, 16'hFFFF);
    store();
    check({hi_data, lo_data} == 16'h5A0F, "R3 capture after hold edge", {hi_data, lo_data}, 16'h5A0F);

    // R7: tied clocks, outputs lag the chain by one pulse
    track = 16'h5A0F;
    both(1'b1);
    check({hi_data, lo_data} == track, "R7 tied pulse 1 takes pre-shift chain", {hi_data, lo_data}, track);
    track = {track[14:0], 1'b1};
    both(1'b0);
    check({hi_data, lo_data} == track, "R7 tied pulse 2 lags one pulse", {hi_data, lo_data}, track);
    track = {track[14:0], 1'b0};

    // R5 / R6: disabled outputs, serial path still live
    out_en_n = 1; #3;
    check(lo_drv == 0 && hi_drv == 0, "R5 drive flag low when disabled", {14'h0, hi_drv, lo_drv}, 16'h0);
    shift_bit(1'b0);
    check(hi_so == track[14], "R6 ser_out driven while disabled", {15'h0, hi_so}, {15'h0, track[14]});
    out_en_n = 0; #3;
    check(lo_drv == 1 && hi_drv == 1, "R5 drive flag high when enabled", {14'h0, hi_drv, lo_drv}, 16'h3);

    // R1 / R4: clear between storage pulses
    shift_word(16'h3C96);
    store();
    clr_n = 0; #3;
    check(lo_so == 0 && hi_so == 0, "R1 clear empties chain at once", {14'h0, hi_so, lo_so}, 16'h0);
    check({hi_data, lo_data} == 16'h3C96, "R4 held word kept in clear", {hi_data, lo_data}, 16'h3C96);
    check({hi_bus, lo_bus} == 16'h3C96, "R4 bus kept in clear", {hi_bus, lo_bus}, 16'h3C96);
    #7; clr_n = 1; #10;
    store();
    check({hi_data, lo_data} == 16'h0, "R1 chain was cleared", {hi_data, lo_data}, 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule